// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block holds the command registers that a processor uses to send an interrupt message to other processors. The command is 64 bits wide and is split into two 32-bit words. Software first writes the upper word, which holds the destination identifier. It then writes the lower word, which holds the vector, the delivery mode, the level and assert flags, and the broadcast-to-all flag. Writing the lower word launches the message.

A launched message is held on a valid/ready output port until the interconnect accepts it. While it waits, a delivery-status bit in the lower word reads as 1. Software polls this bit and waits for it to clear before it writes the next command. For a startup message, software places the page number of the start address (the address shifted right by 12) in the vector field, and the block passes that field on unchanged.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, msg_valid is 0 and reads of the lower word (byte offset 0x300) and the upper word (byte offset 0x310) both return 0.
- R2: A write to offset 0x310 stores wr_data[31:24] as the destination. A read of 0x310 returns the destination in bits [31:24], with all other bits 0.
- R3: A write to offset 0x300 that is accepted raises msg_valid on the next clock edge.
- R4: A read of 0x300 returns the last accepted lower-word fields in their own bit positions: vector [7:0], mode [10:8], assert 14, level 15, broadcast 19. Bit 12 reads as the live delivery status, which equals msg_valid. Every other bit reads as 0.
- R5: A write to 0x300 while a message is pending and not handshaking in that cycle is ignored. The message on the output and the value read back from 0x300 do not change.
- R6: While msg_valid is 1 and msg_ready is 0, every message output holds its value.
- R7: When msg_valid and msg_ready are both 1 at a clock edge, msg_valid falls at that edge, unless R8 applies.
- R8: A write to 0x300 in the same cycle as a completing handshake is accepted. msg_valid stays 1 and the new message appears after that edge.
- R9: When the broadcast bit (bit 19) of a launch is set, msg_dest is all ones. Otherwise msg_dest is the destination stored when the launch happened.
- R10: msg_vector, msg_mode, msg_level, msg_assert and msg_bcast carry the launch word's bits [7:0], [10:8], 15, 14 and 19 unchanged. The mode encodings are 000 fixed, 101 INIT and 110 startup.
- R11: Reads of any other offset return 0. Bit 12 of a lower-word write is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte offset (read data is combinational) |
| rd_data | output | 32 | Read data |
| msg_valid | output | 1 | A message is pending on the output port |
| msg_ready | input | 1 | The interconnect accepts the message |
| msg_dest | output | 8 | Destination identifier (all ones for broadcast) |
| msg_vector | output | 8 | Vector, or start page for a startup message |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level-triggered flag |
| msg_assert | output | 1 | Assert (1) or de-assert (0) |
| msg_bcast | output | 1 | Broadcast to all processors, sender included |

## Verification
Two events can land in the same cycle: a new lower-word write and the completion of the pending message's handshake. The bench provokes this directly, by holding a message pending and then raising msg_ready in the same cycle as a fresh launch. It also provokes it often through random ready and write traffic. A reference model built from the requirements judges the result: the new write must be accepted, msg_valid must stay high, and the new fields must appear. The bench separately checks that a write landing while the message is still stalled is dropped.

// File: rtl/ipi_pkg.sv
// Shared constants and types for the inter-processor interrupt command unit.
// Assumes byte offsets on a 12-bit register window and 32-bit data words.
package ipi_pkg;
    parameter int ADDR_W = 12;
    parameter int DATA_W = 32;
    parameter int DEST_W = 8;
    parameter int VEC_W  = 8;
    parameter int MODE_W = 3;

    localparam logic [ADDR_W-1:0] OFS_LO = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_HI = 12'h310;

    localparam int BIT_MODE   = 8;
    localparam int BIT_BUSY   = 12;
    localparam int BIT_ASSERT = 14;
    localparam int BIT_LEVEL  = 15;
    localparam int BIT_BCAST  = 19;
    localparam int DEST_LSB   = DATA_W - DEST_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_FIXED   = 3'b000,
        MODE_INIT    = 3'b101,
        MODE_STARTUP = 3'b110
    } dmode_e;

    typedef struct packed {
        logic              bcast;
        logic              level;
        logic              asrt;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
    } cmd_lo_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        cmd_lo_t           lo;
    } ipi_msg_t;
endpackage

// File: rtl/ipi_cmd_regs.sv
// Command register storage and read decode.
// Holds the destination word and the last accepted lower-word fields, and
// merges the live busy flag into lower-word reads. Assumes the caller
// qualifies lo_accept with busy and handshake state.
module ipi_cmd_regs
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lo_accept,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    output logic [DEST_W-1:0] dest_q,
    output cmd_lo_t           lo_d,
    output logic [DATA_W-1:0] rd_data
);
    cmd_lo_t lo_q;

    // Extract lower-word fields from the write data.
    always_comb begin
        lo_d.vector = wr_data[VEC_W-1:0];
        lo_d.mode   = wr_data[BIT_MODE +: MODE_W];
        lo_d.asrt   = wr_data[BIT_ASSERT];
        lo_d.level  = wr_data[BIT_LEVEL];
        lo_d.bcast  = wr_data[BIT_BCAST];
    end

    // Store the destination on every upper-word write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dest_q <= '0;
        else if (wr_en && wr_addr == OFS_HI)
            dest_q <= wr_data[DATA_W-1:DEST_LSB];
    end

    // Store the lower-word fields only when a launch is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (lo_accept)
            lo_q <= lo_d;
    end

    // Read decode with the live delivery-status bit merged in.
    always_comb begin
        rd_data = '0;
        if (rd_addr == OFS_LO) begin
            rd_data[VEC_W-1:0]          = lo_q.vector;
            rd_data[BIT_MODE +: MODE_W] = lo_q.mode;
            rd_data[BIT_BUSY]           = busy;
            rd_data[BIT_ASSERT]         = lo_q.asrt;
            rd_data[BIT_LEVEL]          = lo_q.level;
            rd_data[BIT_BCAST]          = lo_q.bcast;
        end else if (rd_addr == OFS_HI) begin
            rd_data[DATA_W-1:DEST_LSB]  = dest_q;
        end
    end

    p_hi_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_HI) |=> (dest_q == $past(wr_data[DATA_W-1:DEST_LSB])));
    p_lo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_accept |=> $stable(lo_q));
endmodule

// File: rtl/ipi_msg_port.sv
// Pending-message register and valid/ready output stage.
// Captures a message on launch, holds it until the handshake completes, and
// drives busy. A broadcast launch forces the destination to all ones.
module ipi_msg_port
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  cmd_lo_t           lo_d,
    input  logic [DEST_W-1:0] dest_q,
    input  logic              msg_ready,
    output logic              msg_valid,
    output ipi_msg_t          msg_q
);
    // Track the pending state: set on launch, clear on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            msg_valid <= 1'b0;
        else if (launch)
            msg_valid <= 1'b1;
        else if (msg_valid && msg_ready)
            msg_valid <= 1'b0;
    end

    // Capture the message contents at launch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            msg_q <= '0;
        else if (launch) begin
            msg_q.lo   <= lo_d;
            msg_q.dest <= lo_d.bcast ? {DEST_W{1'b1}} : dest_q;
        end
    end

    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> msg_valid);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_q)));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && !launch) |=> !msg_valid);
    p_bcast_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_q.lo.bcast) |-> (msg_q.dest == {DEST_W{1'b1}}));
endmodule

// File: rtl/ipi_cmd_unit.sv
// Top of the inter-processor interrupt command unit.
// Decides whether a lower-word write launches a message (idle, or the
// pending one completes its handshake in the same cycle) and wires the
// register and output stages together.
module ipi_cmd_unit
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [DEST_W-1:0] msg_dest,
    output logic [VEC_W-1:0]  msg_vector,
    output logic [MODE_W-1:0] msg_mode,
    output logic              msg_level,
    output logic              msg_assert,
    output logic              msg_bcast
);
    logic              launch;
    logic [DEST_W-1:0] dest_q;
    cmd_lo_t           lo_d;
    ipi_msg_t          msg_q;

    // Accept a launch when idle or when the pending message leaves now.
    always_comb
        launch = wr_en && (wr_addr == OFS_LO) && (!msg_valid || msg_ready);

    ipi_cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lo_accept(launch), .rd_addr(rd_addr),
        .busy(msg_valid), .dest_q(dest_q), .lo_d(lo_d), .rd_data(rd_data)
    );

    ipi_msg_port u_port (
        .clk(clk), .rst_n(rst_n), .launch(launch), .lo_d(lo_d),
        .dest_q(dest_q), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_q(msg_q)
    );

    // Flatten the message onto the output pins.
    always_comb begin
        msg_dest   = msg_q.dest;
        msg_vector = msg_q.lo.vector;
        msg_mode   = msg_q.lo.mode;
        msg_level  = msg_q.lo.level;
        msg_assert = msg_q.lo.asrt;
        msg_bcast  = msg_q.lo.bcast;
    end

    p_busy_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == OFS_LO) |-> (rd_data[BIT_BUSY] == msg_valid));
    p_b2b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && wr_en && wr_addr == OFS_LO) |=> msg_valid);
    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready && wr_en && wr_addr == OFS_LO) |=> $stable(msg_vector));
endmodule

// File: tb/sim_ipi_cmd_unit.sv
// Self-checking bench: random register traffic and random ready, plus
// directed corner cases, compared each cycle against a requirement model.
module sim_ipi_cmd_unit;
    localparam logic [11:0] LO = 12'h300;
    localparam logic [11:0] HI = 12'h310;
    localparam logic [31:0] LO_MASK = 32'h0008C7FF;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [11:0] wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic [11:0] rd_addr = 0;
    logic [31:0] rd_data;
    logic        msg_valid, msg_ready = 0;
    logic [7:0]  msg_dest, msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_level, msg_assert, msg_bcast;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ipi_cmd_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
        .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_level(msg_level),
        .msg_assert(msg_assert), .msg_bcast(msg_bcast)
    );

    // Reference model state, derived from the requirements.
    logic [7:0]  m_dest = 0;
    logic [31:0] m_low = 0;
    logic        m_valid = 0;
    logic [31:0] m_word = 0;
    logic [7:0]  m_mdest = 0;
    bit          ev_ign = 0, ev_b2b = 0, ev_held = 0;

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == LO) return m_low | (32'(m_valid) << 12);
        if (a == HI) return {m_dest, 24'h0};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        bit hs, acc;
        if (!rst_n) begin
            m_dest = 0; m_low = 0; m_valid = 0; m_word = 0; m_mdest = 0;
            ev_ign = 0; ev_b2b = 0; ev_held = 0;
        end else begin
            hs  = m_valid && msg_ready;
            acc = wr_en && wr_addr == LO && (!m_valid || hs);
            ev_ign  = wr_en && wr_addr == LO && m_valid && !hs;
            ev_b2b  = acc && hs;
            ev_held = m_valid && !msg_ready;
            if (wr_en && wr_addr == HI) m_dest = wr_data[31:24];
            if (acc) begin
                m_low   = wr_data & LO_MASK;
                m_word  = wr_data;
                m_mdest = wr_data[19] ? 8'hFF : m_dest;
                m_valid = 1;
            end else if (hs) m_valid = 0;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model, labelling by the situation.
    task automatic compare_all();
        string vtag, ftag, rtag;
        vtag = ev_b2b ? "R8" : (ev_ign ? "R5" : "R3/R7");
        ftag = ev_held ? "R6" : (ev_ign ? "R5" : "R10");
        rtag = (rd_addr == LO) ? "R4" : (rd_addr == HI) ? "R2" : "R11";
        chk(vtag, 32'(msg_valid), 32'(m_valid));
        chk(rtag, rd_data, exp_read(rd_addr));
        if (m_valid) begin
            chk(ftag, {msg_level, msg_assert, msg_bcast, msg_mode, msg_vector},
                {m_word[15], m_word[14], m_word[19], m_word[10:8], m_word[7:0]});
            chk("R9", 32'(msg_dest), 32'(m_mdest));
        end
    endtask

    // One cycle: drive at negedge, check at the next negedge.
    task automatic cyc(bit we, logic [11:0] a, logic [31:0] d, bit rdy, logic [11:0] ra);
        wr_en = we; wr_addr = a; wr_data = d; msg_ready = rdy; rd_addr = ra;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", 32'(msg_valid), 0);
        rd_addr = LO; #0; chk("R1", rd_data, 0);
        rd_addr = HI; #0; chk("R1", rd_data, 0);
        rst_n = 1;
        // R2: destination store
        cyc(1, HI, 32'h2A00_1234, 0, HI);
        // R10: startup, page number 0x07, level-less; R3 launch; R11 bit12 not stored
        cyc(1, LO, 32'h0000_1607, 0, LO);
        // R6: stall, R5: write while stalled is ignored
        cyc(1, LO, 32'h0000_C500, 0, LO);
        cyc(0, 0, 0, 0, LO);
        // R8: handshake plus new INIT level assert write in the same cycle
        cyc(1, LO, 32'h0000_C500, 1, LO);
        // R7: handshake drains
        cyc(0, 0, 0, 1, LO);
        // R9: broadcast INIT de-assert
        cyc(1, LO, 32'h0008_8500, 0, LO);
        cyc(0, 0, 0, 1, LO);
        // R11: unmapped offset
        cyc(1, 12'h320, 32'hFFFF_FFFF, 0, 12'h320);
        cyc(0, 0, 0, 0, 12'h080);
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a, ra;
            int s;
            s = $urandom_range(0, 2);
            a = (s == 0) ? LO : (s == 1) ? HI : 12'h0B0;
            s = $urandom_range(0, 2);
            ra = (s == 0) ? LO : (s == 1) ? HI : 12'h020;
            cyc($urandom_range(0, 2) != 0, a, $urandom, $urandom_range(0, 1) == 1, ra);
        end
        // R1: reset again mid-traffic clears pending state
        rst_n = 0;
        cyc(0, 0, 0, 0, LO);
        rst_n = 1;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule